// File: doc/BRIEF.md
# Multi-cycle RV32I subset core

A 32-bit processor core that executes one instruction at a time, spreading each across several clock cycles. It runs the register-register arithmetic and logic group, word load, word store and branch-if-equal. A single memory port serves both instruction fetch and data access, and one ALU is shared by the program-counter increment, the effective-address sum, the branch-target sum and the operation itself. Values that have to survive from one step to the next sit in internal holding registers: the instruction word, the address of the current instruction, both register operands, the ALU result and the loaded word.

A state machine steps every instruction through fetch and decode and then down a path chosen by its opcode. The fetch step also computes PC+4 and writes it to the program counter. The decode step computes the branch target from the saved instruction address while the register file is read. Every path ends by returning to fetch. The memory is external. Its read data is combinational in the address, and a write takes effect on the rising edge when the write enable is high.

Top module: `mc_core`

## Requirements
- R1: While rst_ni is low the program counter is 0 and the core is in the fetch step. The first cycle after release fetches from address 0, and no memory write occurs before the first store.
- R2: In every fetch cycle mem_addr_o equals the program counter. Unless a branch is taken, the next instruction is fetched from the current address plus 4.
- R3: An instruction with opcode 0110011 writes rd (bits 11:7) with the result of rs1 (bits 19:15) and rs2 (bits 24:20), chosen by funct3 (bits 14:12) and bit 30. 000 gives add, or sub when bit 30 is set. 001 gives sll, 100 xor, 101 srl, or sra when bit 30 is set, 110 or, and 111 and. Shifts use the low 5 bits of rs2. The instruction takes 4 cycles.
- R4: Opcode 0000011 loads the word at rs1 + sign-extended bits 31:20 into rd and takes 5 cycles.
- R5: Opcode 0100011 writes rs2 to address rs1 + sign-extended {bits 31:25, bits 11:7} and takes 4 cycles.
- R6: Opcode 1100011 compares rs1 and rs2 by subtraction. When they are equal, the next fetch is at the branch's own address + sign-extended {bit 31, bit 7, bits 30:25, bits 11:8, 0}. Otherwise it is at the address + 4. It takes 3 cycles.
- R7: Register 0 always reads as zero, and writes to it are dropped.
- R8: Any other opcode spends 2 cycles, writes neither a register nor memory, and continues at its address + 4.
- R9: mem_we_o is high for exactly one cycle per executed store and at no other time. In that cycle mem_addr_o is the computed address and mem_wdata_o is the rs2 value.
- R10: funct3 010 (slt) gives 1 when rs1 < rs2 as signed numbers, and 011 (sltu) does the same as unsigned numbers. Both are derived from the subtraction's sign, carry and overflow flags, including the cases where the subtraction overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 32 | Memory byte address (PC on fetch, computed address otherwise) |
| mem_wdata_o | output | 32 | Store data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 32 | Memory read data, combinational in mem_addr_o |

## Verification
Two pieces of work overlap in time. In fetch, the shared ALU produces PC+4 while the memory port returns the instruction. In decode, the branch target is formed while the register operands are read. The branch step then reuses the ALU for the compare, and the program counter is loaded from the target held since decode. Each operand pair, equal and unequal, runs a branch that sits between a not-taken and a taken store. The core must fetch from the target on the exact cycle it should, the other store must stay unwritten, and the address and data of the first store must arrive on the cycle that the sum of per-instruction latencies predicts.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam logic [6:0] OP_LOAD  = 7'b0000011;
  localparam logic [6:0] OP_STORE = 7'b0100011;
  localparam logic [6:0] OP_ARITH = 7'b0110011;
  localparam logic [6:0] OP_BEQ   = 7'b1100011;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_MEMADR, ST_MEMRD, ST_MEMWB,
    ST_MEMWR, ST_EXEC, ST_ALUWB, ST_BRANCH
  } state_e;

  typedef enum logic [3:0] {
    ALU_ADD  = 4'd0,
    ALU_SUB  = 4'd1,
    ALU_AND  = 4'd2,
    ALU_OR   = 4'd3,
    ALU_XOR  = 4'd4,
    ALU_SLT  = 4'd5,
    ALU_SLTU = 4'd6,
    ALU_SLL  = 4'd7,
    ALU_SRL  = 4'd8,
    ALU_SRA  = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {SRCA_PC, SRCA_OLDPC, SRCA_REG} srca_e;
  typedef enum logic [1:0] {SRCB_RS2, SRCB_IMM, SRCB_STEP} srcb_e;
  typedef enum logic [1:0] {IMM_I, IMM_S, IMM_B} imm_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    logic    ir_we;
    logic    pc_inc;
    logic    branch;
    logic    adr_alu;
    logic    mem_we;
    logic    rf_we;
    logic    res_data;
    srca_e   srca;
    srcb_e   srcb;
    imm_e    imm_sel;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/mc_alu.sv
module mc_alu import mc_pkg::*; #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output logic         zero_o
);
  localparam int SHW = $clog2(W);

  logic         sub;
  logic [W-1:0] b_eff;
  logic [W:0]   sum;
  flags_t       fl;

  assign sub   = (op_i == ALU_SUB) || (op_i == ALU_SLT) || (op_i == ALU_SLTU);
  assign b_eff = sub ? ~b_i : b_i;
  assign sum   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub};

  always_comb begin
    unique case (op_i)
      ALU_ADD, ALU_SUB: res_o = sum[W-1:0];
      ALU_AND:  res_o = a_i & b_i;
      ALU_OR:   res_o = a_i | b_i;
      ALU_XOR:  res_o = a_i ^ b_i;
      ALU_SLT:  res_o = {{(W-1){1'b0}}, fl.n ^ fl.v};
      ALU_SLTU: res_o = {{(W-1){1'b0}}, ~fl.c};
      ALU_SLL:  res_o = a_i << b_i[SHW-1:0];
      ALU_SRL:  res_o = a_i >> b_i[SHW-1:0];
      ALU_SRA:  res_o = $unsigned($signed(a_i) >>> b_i[SHW-1:0]);
      default:  res_o = sum[W-1:0];
    endcase
  end

  // flags of the adder; z reflects the selected result
  assign fl.n   = sum[W-1];
  assign fl.c   = sum[W];
  assign fl.v   = (a_i[W-1] == b_eff[W-1]) && (sum[W-1] != a_i[W-1]);
  assign fl.z   = (res_o == '0);
  assign zero_o = fl.z;

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra1_i,
  input  logic [AW-1:0] ra2_i,
  output logic [W-1:0]  rd1_o,
  output logic [W-1:0]  rd2_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] q [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    // entry 0 has no write path and stays zero
    localparam bit WRITABLE = (g != 0);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    q[g] <= '0;
      else if (WRITABLE && we_i && wa_i == AW'(g))    q[g] <= wd_i;
    end
  end

  assign rd1_o = q[ra1_i];
  assign rd2_o = q[ra2_i];

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl import mc_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [6:0] opcode_i,
  input  logic [2:0] funct3_i,
  input  logic       alt_i,
  output state_e     state_o,
  output ctrl_t      ctl_o
);
  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = ST_FETCH;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        unique case (opcode_i)
          OP_LOAD, OP_STORE: state_d = ST_MEMADR;
          OP_ARITH:          state_d = ST_EXEC;
          OP_BEQ:            state_d = ST_BRANCH;
          default:           state_d = ST_FETCH;
        endcase
      end
      ST_MEMADR: state_d = (opcode_i == OP_LOAD) ? ST_MEMRD : ST_MEMWR;
      ST_MEMRD:  state_d = ST_MEMWB;
      ST_EXEC:   state_d = ST_ALUWB;
      default:   state_d = ST_FETCH;
    endcase
  end

  alu_op_e arith_op;
  always_comb begin
    unique case (funct3_i)
      3'b000:  arith_op = alt_i ? ALU_SUB : ALU_ADD;
      3'b001:  arith_op = ALU_SLL;
      3'b010:  arith_op = ALU_SLT;
      3'b011:  arith_op = ALU_SLTU;
      3'b100:  arith_op = ALU_XOR;
      3'b101:  arith_op = alt_i ? ALU_SRA : ALU_SRL;
      3'b110:  arith_op = ALU_OR;
      default: arith_op = ALU_AND;
    endcase
  end

  always_comb begin
    ctl_o = '{ir_we: 1'b0, pc_inc: 1'b0, branch: 1'b0, adr_alu: 1'b1,
              mem_we: 1'b0, rf_we: 1'b0, res_data: 1'b0, srca: SRCA_REG,
              srcb: SRCB_IMM, imm_sel: IMM_I, alu_op: ALU_ADD};
    unique case (state_q)
      ST_FETCH: begin
        ctl_o.adr_alu = 1'b0;
        ctl_o.ir_we   = 1'b1;
        ctl_o.pc_inc  = 1'b1;
        ctl_o.srca    = SRCA_PC;
        ctl_o.srcb    = SRCB_STEP;
      end
      ST_DECODE: begin
        ctl_o.srca    = SRCA_OLDPC;
        ctl_o.imm_sel = IMM_B;
      end
      ST_MEMADR:  ctl_o.imm_sel = (opcode_i == OP_STORE) ? IMM_S : IMM_I;
      ST_MEMWB: begin
        ctl_o.rf_we    = 1'b1;
        ctl_o.res_data = 1'b1;
      end
      ST_MEMWR:   ctl_o.mem_we = 1'b1;
      ST_EXEC: begin
        ctl_o.srcb   = SRCB_RS2;
        ctl_o.alu_op = arith_op;
      end
      ST_ALUWB:   ctl_o.rf_we = 1'b1;
      ST_BRANCH: begin
        ctl_o.srcb   = SRCB_RS2;
        ctl_o.alu_op = ALU_SUB;
        ctl_o.branch = 1'b1;
      end
      default: ;
    endcase
  end

  assign state_o = state_q;

endmodule

// File: rtl/mc_core.sv
module mc_core import mc_pkg::*; #(
  parameter int W     = 32,
  parameter int NREGS = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] mem_addr_o,
  output logic [W-1:0] mem_wdata_o,
  output logic         mem_we_o,
  input  logic [W-1:0] mem_rdata_i
);
  localparam int          RAW  = $clog2(NREGS);
  localparam logic [W-1:0] STEP = W'(W / 8);

  state_e       state;
  ctrl_t        ctl;
  logic [W-1:0] pc_q, old_pc_q, ir_q, a_q, wd_q, alu_out_q, data_q;
  logic [W-1:0] rd1, rd2, imm, src_a, src_b, alu_res, rf_wd;
  logic         alu_zero;

  mc_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (ir_q[6:0]),
    .funct3_i (ir_q[14:12]),
    .alt_i    (ir_q[30]),
    .state_o  (state),
    .ctl_o    (ctl)
  );

  always_comb begin
    unique case (ctl.imm_sel)
      IMM_S:   imm = {{(W-11){ir_q[31]}}, ir_q[30:25], ir_q[11:7]};
      IMM_B:   imm = {{(W-12){ir_q[31]}}, ir_q[7], ir_q[30:25], ir_q[11:8], 1'b0};
      default: imm = {{(W-11){ir_q[31]}}, ir_q[30:20]};
    endcase
  end

  mc_regfile #(.W(W), .N(NREGS)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra1_i  (ir_q[15 +: RAW]),
    .ra2_i  (ir_q[20 +: RAW]),
    .rd1_o  (rd1),
    .rd2_o  (rd2),
    .we_i   (ctl.rf_we),
    .wa_i   (ir_q[7 +: RAW]),
    .wd_i   (rf_wd)
  );

  always_comb begin
    unique case (ctl.srca)
      SRCA_PC:    src_a = pc_q;
      SRCA_OLDPC: src_a = old_pc_q;
      default:    src_a = a_q;
    endcase
    unique case (ctl.srcb)
      SRCB_RS2:  src_b = wd_q;
      SRCB_STEP: src_b = STEP;
      default:   src_b = imm;
    endcase
  end

  mc_alu #(.W(W)) u_alu (
    .a_i    (src_a),
    .b_i    (src_b),
    .op_i   (ctl.alu_op),
    .res_o  (alu_res),
    .zero_o (alu_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q      <= '0;
      old_pc_q  <= '0;
      ir_q      <= '0;
      a_q       <= '0;
      wd_q      <= '0;
      alu_out_q <= '0;
      data_q    <= '0;
    end else begin
      if (ctl.ir_we) begin
        ir_q     <= mem_rdata_i;
        old_pc_q <= pc_q;
      end
      if (ctl.pc_inc)                   pc_q <= alu_res;
      else if (ctl.branch && alu_zero)  pc_q <= alu_out_q;  // target from decode
      a_q       <= rd1;
      wd_q      <= rd2;
      alu_out_q <= alu_res;
      data_q    <= mem_rdata_i;
    end
  end

  assign rf_wd       = ctl.res_data ? data_q : alu_out_q;
  assign mem_addr_o  = ctl.adr_alu ? alu_out_q : pc_q;
  assign mem_wdata_o = wd_q;
  assign mem_we_o    = ctl.mem_we;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk import mc_pkg::*; #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input state_e       state_i,
  input logic [W-1:0] pc_i,
  input logic [W-1:0] ir_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] wd_i,
  input logic [W-1:0] alu_out_i,
  input logic [W-1:0] rd1_i,
  input logic         zero_i,
  input logic         mem_we_i,
  input logic [W-1:0] mem_addr_i
);
  logic known_op;
  assign known_op = (ir_i[6:0] == OP_LOAD) || (ir_i[6:0] == OP_STORE) ||
                    (ir_i[6:0] == OP_ARITH) || (ir_i[6:0] == OP_BEQ);

  // R2
  fetch_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_FETCH |-> mem_addr_i == pc_i);
  // R2
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_FETCH |=> pc_i == $past(pc_i) + W'(4));
  // R6
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_FETCH && state_i != ST_BRANCH) |=> $stable(pc_i));
  // R6
  beq_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_BRANCH && a_i == wd_i) |=> pc_i == $past(alu_out_i));
  // R6
  beq_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_BRANCH |-> zero_i == (a_i == wd_i));
  // R7
  x0_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_i[19:15] == 5'd0 |-> rd1_i == '0);
  // R8
  bad_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DECODE && !known_op) |=> state_i == ST_FETCH);
  // R9
  we_only_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> state_i == ST_MEMWR);
  // R9
  we_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> !mem_we_i);
  // R4
  load_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_MEMRD |=> state_i == ST_MEMWB);
  // R3
  arith_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_EXEC |=> state_i == ST_ALUWB);

endmodule

bind mc_core mc_core_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .state_i    (state),
  .pc_i       (pc_q),
  .ir_i       (ir_q),
  .a_i        (a_q),
  .wd_i       (wd_q),
  .alu_out_i  (alu_out_q),
  .rd1_i      (rd1),
  .zero_i     (alu_zero),
  .mem_we_i   (mem_we_o),
  .mem_addr_i (mem_addr_o)
);

// File: tb/mc_core_bench.sv
module mc_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 300;
  localparam int WDOG       = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;
  logic [31:0] mem [256];
  logic [31:0] trace [128];
  int          cyc, total, n_chk, n_fail, we_count, first_we_cyc;
  logic [31:0] first_we_addr, first_we_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mc_core u_mc_core (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_we_o    (mem_we),
    .mem_rdata_i (mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    total <= total + 1;
    if (total > WDOG) begin
      n_fail = n_fail + 1;
      $display("FAIL R1 watchdog expired act=%0d exp<%0d", total, WDOG);
      summary();
      $finish;
    end
  end

  // sampled mid-cycle: cyc equals the cycle index since reset release
  always @(negedge clk) begin
    if (rst_n) begin
      if (cyc < 128) trace[cyc] = mem_addr;
      if (mem_we) begin
        if (we_count == 0) begin
          first_we_cyc  = cyc;
          first_we_addr = mem_addr;
          first_we_data = mem_wdata;
        end
        we_count = we_count + 1;
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(logic [6:0] f7, int rs2, int rs1, logic [2:0] f3, int rd);
    return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'b0110011};
  endfunction
  function automatic logic [31:0] enc_lw(int rd, int rs1, int imm);
    logic [11:0] i = 12'(imm);
    return {i, 5'(rs1), 3'b010, 5'(rd), 7'b0000011};
  endfunction
  function automatic logic [31:0] enc_sw(int rs2, int rs1, int imm);
    logic [11:0] i = 12'(imm);
    return {i[11:5], 5'(rs2), 5'(rs1), 3'b010, i[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_beq(int rs1, int rs2, int imm);
    logic [12:0] i = 13'(imm);
    return {i[12], i[10:5], 5'(rs2), 5'(rs1), 3'b000, i[4:1], i[11], 7'b1100011};
  endfunction

  task automatic run_vec(logic [31:0] a, logic [31:0] b);
    logic [31:0] exp_r [10];
    logic        eq;
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 128; i++) trace[i] = '0;
    we_count = 0;
    first_we_cyc = -1;
    mem[0]  = enc_lw(1, 0, 'h200);
    mem[1]  = enc_lw(2, 0, 'h204);
    mem[2]  = enc_r(7'h00, 2, 1, 3'd0, 3);
    mem[3]  = enc_r(7'h20, 2, 1, 3'd0, 4);
    mem[4]  = enc_r(7'h00, 2, 1, 3'd7, 5);
    mem[5]  = enc_r(7'h00, 2, 1, 3'd6, 6);
    mem[6]  = enc_r(7'h00, 2, 1, 3'd4, 7);
    mem[7]  = enc_r(7'h00, 2, 1, 3'd2, 8);
    mem[8]  = enc_r(7'h00, 2, 1, 3'd3, 9);
    mem[9]  = enc_r(7'h00, 2, 1, 3'd1, 10);
    mem[10] = enc_r(7'h00, 2, 1, 3'd5, 11);
    mem[11] = enc_r(7'h20, 2, 1, 3'd5, 12);
    for (int k = 0; k < 10; k++) mem[12 + k] = enc_sw(3 + k, 0, 'h300 + 4 * k);
    mem[22] = enc_r(7'h00, 2, 1, 3'd0, 0);
    mem[23] = enc_sw(0, 0, 'h328);
    mem[24] = 32'h0000_007F;
    mem[25] = enc_beq(1, 2, 12);
    mem[26] = enc_sw(1, 0, 'h32C);
    mem[27] = enc_beq(0, 0, 8);
    mem[28] = enc_sw(2, 0, 'h330);
    mem[29] = enc_lw(14, 0, 'h208);
    mem[30] = enc_sw(1, 14, -8);
    mem[31] = enc_lw(15, 14, -4);
    mem[32] = enc_sw(15, 0, 'h334);
    mem[33] = enc_beq(0, 0, 0);
    mem[128] = a;
    mem[129] = b;
    mem[130] = 32'h348;
    mem[209] = a ^ 32'h5A5A_0F0F;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: state held in reset
    chk("R1 reset fetch address", mem_addr, 32'h0);
    chk("R1 no write in reset", {31'b0, mem_we}, 32'h0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (RUN_CYCLES) @(posedge clk);
    @(negedge clk);

    exp_r[0] = a + b;
    exp_r[1] = a - b;
    exp_r[2] = a & b;
    exp_r[3] = a | b;
    exp_r[4] = a ^ b;
    exp_r[5] = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    exp_r[6] = (a < b) ? 32'd1 : 32'd0;
    exp_r[7] = a << b[4:0];
    exp_r[8] = a >> b[4:0];
    exp_r[9] = $unsigned($signed(a) >>> b[4:0]);
    eq = (a == b);

    chk("R1 first fetch at 0", trace[0], 32'h0);
    chk("R4 lw takes 5 cycles", trace[5], 32'h4);
    chk("R2 sequential fetch", trace[10], 32'h8);
    chk("R3 arith takes 4 cycles", trace[14], 32'hC);
    chk("R5 sw takes 4 cycles", trace[54], 32'h34);
    chk("R8 bad opcode fetched", trace[98], 32'h60);
    chk("R8 bad opcode takes 2 cycles", trace[100], 32'h64);
    chk("R6 beq next fetch", trace[103], eq ? 32'h70 : 32'h68);
    chk("R6 beq 3 cycles follow-on", trace[107], eq ? 32'h74 : 32'h6C);
    chk("R9 first write cycle", 32'(first_we_cyc), 32'd53);
    chk("R9 first write address", first_we_addr, 32'h300);
    chk("R9 first write data", first_we_data, a + b);
    chk("R9 write count", 32'(we_count), 32'd14);
    chk("R3 add", mem[192], exp_r[0]);
    chk("R3 sub", mem[193], exp_r[1]);
    chk("R3 and", mem[194], exp_r[2]);
    chk("R3 or", mem[195], exp_r[3]);
    chk("R3 xor", mem[196], exp_r[4]);
    chk("R10 slt", mem[197], exp_r[5]);
    chk("R10 sltu", mem[198], exp_r[6]);
    chk("R3 sll", mem[199], exp_r[7]);
    chk("R3 srl", mem[200], exp_r[8]);
    chk("R3 sra", mem[201], exp_r[9]);
    chk("R7 x0 stays zero", mem[202], 32'h0);
    chk("R6 not-taken slot", mem[203], eq ? 32'h0 : a);
    chk("R6 taken slot", mem[204], eq ? b : 32'h0);
    chk("R5 negative store offset", mem[208], a);
    chk("R4 negative load offset", mem[205], a ^ 32'h5A5A_0F0F);
    chk("R8 no stray write", mem[206], 32'h0);
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    total = 0;
    run_vec(32'h0000_0000, 32'h0000_0000);
    run_vec(32'h0000_0005, 32'h0000_0003);
    run_vec(32'h7FFF_FFFF, 32'h0000_0001);
    run_vec(32'h8000_0000, 32'h0000_0001);
    run_vec(32'h7FFF_FFFF, 32'hFFFF_FFFF);
    run_vec(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_vec(32'h0000_0001, 32'h8000_0000);
    run_vec(32'h8000_0000, 32'h7FFF_FFFF);
    run_vec(32'hF0F0_1234, 32'h0000_003F);
    for (int i = 0; i < 16; i++) begin
      logic [31:0] va = 32'h9E37_79B9 * 32'(i + 1);
      logic [31:0] vb = (i % 4 == 0) ? va : 32'h85EB_CA6B * 32'(i + 3);
      run_vec(va, vb);
    end
    summary();
    $finish;
  end

endmodule